// File: doc/BRIEF.md
# SMBus Slave Transmit Controller

This block is the slave side of a two-wire SMBus/I2C link that answers read requests. It brings the clock and data lines into the system clock domain, finds START and STOP conditions, and shifts in seven address bits plus a direction bit. When a read is aimed at its own address, it raises an interrupt flag and holds the clock line low. Firmware then answers: it may load a byte, and it chooses ACK or NACK before clearing the flag. After an ACK, the engine shifts the loaded bytes out MSB first. After each byte it samples the master's acknowledge bit and raises the flag again.

Firmware loads bytes through a valid/ready port. A byte moves on a rising clock edge that sees both `tx_valid` and `tx_ready` high. `tx_ready` follows the interrupt flag, so the port applies back-pressure whenever the engine is not waiting on firmware. There is one data register. A second accepted write in the same flag window replaces the first.

If firmware declines the address, interrupts stay silent until the next START. If firmware clears the flag without supplying a byte, the engine drops into a passive receive fallback. If firmware writes a byte after the master has answered NACK, an error bit is set.

Top module: `smb_slave_tx`

## Requirements
- R1: While `inhibit` is 1, a read to the own address raises no flag, and SDA stays released during the ninth clock pulse (NACK).
- R2: The first seven bits after a START, taken MSB first, are compared with `own_addr`. The eighth bit is the direction, where 1 means read. On a match with read, `si` and `ack_req` rise after the SCL fall that ends the eighth bit. While `si` is 1, `scl_oe` is 1.
- R3: If firmware clears the flag with `ack_sel`=0, the address is NACKed. No flag is raised for any further clocking until a new START. A repeated START that carries a matching read address raises the flag again.
- R4: If firmware clears the flag with `ack_sel`=1, SDA is pulled low for the ninth pulse. The byte accepted on the tx port is then shifted out MSB first, starting on the SCL fall that ends the ack pulse. `tx_ready` equals `si`.
- R5: The byte-done flag rises only after the SCL fall that ends the master's acknowledge pulse, and never before it. `master_nack` holds the sampled acknowledge, where 1 means NACK. SDA is released while the flag is set.
- R6: After a master ACK, a byte loaded before the flag is cleared is sent next. Any number of bytes may follow in sequence.
- R7: A write accepted while the flag is set after a master NACK sets `wr_err`, and the byte is not sent. The next START clears `wr_err`.
- R8: If the flag is cleared with no byte loaded, either after an ACKed address or after an ACKed byte, the engine enters the receive fallback. In that state `rx_fb`=1 and `tx_mode`=0, SDA stays released so the master reads 0xFF, and no further flag is raised.
- R9: A STOP (SDA rising while SCL is high) ends transmit mode and clears `si` and `ack_req`. A START is SDA falling while SCL is high.
- R10: A mismatched address, or the own address with direction 0, raises no flag and is not acknowledged.
- R11: After reset, `si`, `ack_req`, `wr_err`, `scl_oe`, `sda_oe`, `tx_mode`, `rx_fb` and `tx_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | ADDR_W | Own slave address |
| inhibit | input | 1 | 1 blocks slave events |
| ack_sel | input | 1 | Firmware answer for the address, where 1 means ACK |
| si_clear | input | 1 | Pulse that clears the interrupt flag |
| tx_data | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Engine accepts a byte (equals si) |
| si | output | 1 | Interrupt flag |
| ack_req | output | 1 | Address awaiting an ACK/NACK decision |
| master_nack | output | 1 | Last acknowledge sampled from the master, where 1 means NACK |
| wr_err | output | 1 | Byte written after a master NACK |
| tx_mode | output | 1 | Engine is transmitting data bytes |
| rx_fb | output | 1 | Engine is in the receive fallback |

## Verification
The hardest state to reach is the suppressed window after a NACKed address. It is only visible as a flag that never rises while the master keeps clocking. The bench declines the address, clocks nine more bits without a START, and checks every clock that the flag stays low. It then issues a repeated START and expects the flag back. A second hard case is the point just before the acknowledge pulse. The bench stops after the eighth data bit to confirm the flag is still low, then clocks the acknowledge. The write-after-NACK error needs a full read ending in a NACK, followed by a write while the flag is still up.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AWAIT,
    S_AACK,
    S_TXBIT,
    S_TXACK,
    S_TWAIT,
    S_RXFB,
    S_QUIET
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA edges only count as conditions while SCL is high in both samples
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_slv_fsm.sv
module smb_slv_fsm
  import smb_slv_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              inhibit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_sel,
  input  logic              si_clear,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              si,
  output logic              ack_req,
  output logic              wr_err,
  output logic              master_nack,
  output logic              tx_mode,
  output logic              rx_fb,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              quiet
);
  localparam int FRAME = ADDR_W + 1;
  localparam int SH_W  = (FRAME > DATA_W) ? FRAME : DATA_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  smb_state_e        state;
  logic [SH_W-1:0]   shreg;
  logic [DATA_W-1:0] dreg;
  logic              dfull;
  logic [CNT_W-1:0]  cnt;
  logic              tail;
  logic              take;
  logic              hit;

  assign take = tx_valid & si;
  assign hit  = (shreg[FRAME-1:1] == own_addr) & shreg[0] & ~inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      shreg       <= '0;
      dreg        <= '0;
      dfull       <= 1'b0;
      cnt         <= '0;
      si          <= 1'b0;
      ack_req     <= 1'b0;
      wr_err      <= 1'b0;
      master_nack <= 1'b0;
      tail        <= 1'b0;
    end else begin
      tail <= 1'b0;
      if (start_det) begin
        state       <= S_ADDR;
        cnt         <= '0;
        si          <= 1'b0;
        ack_req     <= 1'b0;
        wr_err      <= 1'b0;
        master_nack <= 1'b0;
        dfull       <= 1'b0;
      end else if (stop_det) begin
        state   <= S_IDLE;
        si      <= 1'b0;
        ack_req <= 1'b0;
        dfull   <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise && cnt != CNT_W'(FRAME)) begin
              shreg <= {shreg[SH_W-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == CNT_W'(FRAME)) begin
              if (hit) begin
                state   <= S_AWAIT;
                si      <= 1'b1;
                ack_req <= 1'b1;
              end else begin
                state <= S_QUIET;
              end
            end
          end
          S_AWAIT: begin
            if (take) begin
              dreg  <= tx_data;
              dfull <= 1'b1;
            end
            if (si_clear) begin
              si      <= 1'b0;
              ack_req <= 1'b0;
              tail    <= 1'b1;
              state   <= ack_sel ? S_AACK : S_QUIET;
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              if (dfull) begin
                shreg <= SH_W'(dreg);
                dfull <= 1'b0;
                cnt   <= '0;
                state <= S_TXBIT;
              end else begin
                state <= S_RXFB;
              end
            end
          end
          S_TXBIT: begin
            if (scl_fall) begin
              shreg <= shreg << 1;
              cnt   <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(DATA_W - 1)) state <= S_TXACK;
            end
          end
          S_TXACK: begin
            if (scl_rise) master_nack <= sda_s;
            if (scl_fall) begin
              si    <= 1'b1;
              state <= S_TWAIT;
            end
          end
          S_TWAIT: begin
            if (take) begin
              if (master_nack) begin
                wr_err <= 1'b1;
              end else begin
                dreg  <= tx_data;
                dfull <= 1'b1;
              end
            end
            if (si_clear) begin
              si   <= 1'b0;
              tail <= 1'b1;
              if (master_nack) begin
                state <= S_QUIET;
              end else if (take || dfull) begin
                shreg <= take ? SH_W'(tx_data) : SH_W'(dreg);
                dfull <= 1'b0;
                cnt   <= '0;
                state <= S_TXBIT;
              end else begin
                state <= S_RXFB;
              end
            end
          end
          S_IDLE, S_RXFB, S_QUIET: ;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign tx_ready = si;
  assign scl_oe   = si | tail;
  assign sda_oe   = (state == S_AACK) | ((state == S_TXBIT) & ~shreg[DATA_W-1]);
  assign tx_mode  = (state == S_TXBIT) | (state == S_TXACK) | (state == S_TWAIT);
  assign rx_fb    = (state == S_RXFB);
  assign quiet    = (state == S_QUIET);
endmodule

// File: rtl/smb_slave_tx.sv
module smb_slave_tx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              inhibit,
  input  logic              ack_sel,
  input  logic              si_clear,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              si,
  output logic              ack_req,
  output logic              master_nack,
  output logic              wr_err,
  output logic              tx_mode,
  output logic              rx_fb
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, sync_lines;
  logic scl_rise, scl_fall, start_det, stop_det, quiet;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines[g]),
      .q     (sync_lines[g])
    );
  end

  smb_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (sync_lines[0]),
    .sda_s     (sync_lines[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_slv_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .sda_s       (sync_lines[1]),
    .inhibit     (inhibit),
    .own_addr    (own_addr),
    .ack_sel     (ack_sel),
    .si_clear    (si_clear),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .si          (si),
    .ack_req     (ack_req),
    .wr_err      (wr_err),
    .master_nack (master_nack),
    .tx_mode     (tx_mode),
    .rx_fb       (rx_fb),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .quiet       (quiet)
  );
endmodule

// File: rtl/smb_slave_tx_chk.sv
module smb_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic inhibit,
  input logic si,
  input logic ack_req,
  input logic wr_err,
  input logic master_nack,
  input logic tx_mode,
  input logic scl_oe,
  input logic sda_oe,
  input logic stop_det,
  input logic quiet
);
  AST_STRETCH_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n) si |-> scl_oe); // R2
  AST_ACKRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) ack_req |-> si); // R2
  AST_INHIBIT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(ack_req) |-> !$past(inhibit)); // R1
  AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) quiet |=> !si); // R3
  AST_SDA_FREE_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n) si |-> !sda_oe); // R5
  AST_ERR_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_err) |-> ($past(master_nack) && $past(si))); // R7
  AST_STOP_ENDS_TX: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> (!tx_mode && !si)); // R9
endmodule

bind smb_slave_tx smb_slave_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inhibit     (inhibit),
  .si          (si),
  .ack_req     (ack_req),
  .wr_err      (wr_err),
  .master_nack (master_nack),
  .tx_mode     (tx_mode),
  .scl_oe      (scl_oe),
  .sda_oe      (sda_oe),
  .stop_det    (stop_det),
  .quiet       (quiet)
);

// File: tb/smb_slave_tx_tb.sv
module smb_slave_tx_tb;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, m_scl_low, m_sda_low;
  logic inhibit, ack_sel, si_clear, tx_valid;
  logic [6:0] own_addr;
  logic [7:0] tx_data;
  logic scl_oe, sda_oe, tx_ready, si, ack_req, master_nack, wr_err, tx_mode, rx_fb;
  logic scl_line, sda_line;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  smb_slave_tx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .inhibit(inhibit),
    .ack_sel(ack_sel), .si_clear(si_clear), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .si(si), .ack_req(ack_req), .master_nack(master_nack),
    .wr_err(wr_err), .tx_mode(tx_mode), .rx_fb(rx_fb)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit irq_ok = 0;
  logic [7:0] exp_q[$];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural monitor, every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (si && !irq_ok) begin
        n_fail++;
        $display("FAIL R3/R1/R8 flag not allowed act=1 exp=0");
      end
      if (si && !scl_oe) begin
        n_fail++;
        $display("FAIL R2 stretch act=0 exp=1");
      end
    end
  end

  task automatic wait_scl_high();
    while (!scl_line) tick(1);
  endtask

  task automatic m_start();
    m_sda_low = 0; tick(Q);
    m_scl_low = 0; wait_scl_high(); tick(Q);
    m_sda_low = 1; tick(Q);
    m_scl_low = 1; tick(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1; tick(Q);
    m_scl_low = 0; wait_scl_high(); tick(Q);
    m_sda_low = 0; tick(Q);
  endtask

  task automatic m_bit_out(input bit b);
    m_sda_low = !b; tick(Q);
    m_scl_low = 0; wait_scl_high(); tick(Q);
    m_scl_low = 1; tick(Q);
  endtask

  task automatic m_bit_in(output bit b);
    m_sda_low = 0; tick(Q);
    m_scl_low = 0; wait_scl_high(); tick(Q);
    b = sda_line;
    m_scl_low = 1; tick(Q);
  endtask

  task automatic addr_phase(input logic [6:0] a, input bit rd);
    for (int i = 6; i >= 0; i--) m_bit_out(a[i]);
    m_bit_out(rd);
  endtask

  task automatic read_byte(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_in(b);
      v[i] = b;
    end
  endtask

  task automatic fw_write(input logic [7:0] d);
    tx_data = d; tx_valid = 1;
    chk("R4 tx_ready with flag", tx_ready, 1);
    tick(1);
    tx_valid = 0;
  endtask

  task automatic fw_clear(input bit ack);
    ack_sel = ack; si_clear = 1;
    tick(1);
    si_clear = 0;
  endtask

  task automatic open_read();
    irq_ok = 1;
    m_start();
    addr_phase(OWN, 1);
    chk("R2 flag on match", si, 1);
    chk("R2 ack_req on match", ack_req, 1);
    chk("R2 scl held", scl_oe, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit b;
    logic [7:0] v;
    rst_n = 0; m_scl_low = 0; m_sda_low = 0; inhibit = 0; own_addr = OWN;
    ack_sel = 0; si_clear = 0; tx_data = 0; tx_valid = 0;
    tick(5); rst_n = 1; tick(3);

    // R11 reset state
    chk("R11 si", si, 0);
    chk("R11 ack_req", ack_req, 0);
    chk("R11 wr_err", wr_err, 0);
    chk("R11 scl_oe", scl_oe, 0);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 tx_mode", tx_mode, 0);
    chk("R11 rx_fb", rx_fb, 0);
    chk("R11 tx_ready", tx_ready, 0);

    // multi-byte read, ended by STOP mid-transfer
    open_read();
    fw_write(8'hA5); exp_q.push_back(8'hA5);
    fw_clear(1);
    m_bit_in(b); chk("R4 address ACK", b, 0);
    read_byte(v); chk("R4 byte msb first", v, exp_q.pop_front());
    chk("R5 no flag before ack pulse", si, 0);
    m_bit_out(0);
    chk("R5 flag after ack pulse", si, 1);
    chk("R5 master ack sampled", master_nack, 0);
    chk("R5 sda free", sda_oe, 0);
    chk("R6 tx_mode", tx_mode, 1);
    fw_write(8'h3C); exp_q.push_back(8'h3C);
    fw_clear(1);
    read_byte(v); chk("R6 second byte", v, exp_q.pop_front());
    m_bit_out(0);
    chk("R6 flag again", si, 1);
    fw_write(8'hC3);
    fw_clear(1);
    tick(2);
    chk("R9 tx_mode before stop", tx_mode, 1);
    m_stop(); tick(2);
    chk("R9 tx_mode after stop", tx_mode, 0);
    chk("R9 si after stop", si, 0);

    // master NACK then a write: error
    open_read();
    fw_write(8'h5A); exp_q.push_back(8'h5A);
    fw_clear(1);
    m_bit_in(b); chk("R4 address ACK", b, 0);
    read_byte(v); chk("R4 byte", v, exp_q.pop_front());
    m_bit_out(1);
    chk("R5 flag after nack", si, 1);
    chk("R5 master nack sampled", master_nack, 1);
    fw_write(8'h11);
    chk("R7 error set", wr_err, 1);
    fw_clear(0);
    irq_ok = 0;
    m_stop();
    m_start(); tick(2);
    chk("R7 error cleared by START", wr_err, 0);
    inhibit = 1;
    addr_phase(OWN, 1);
    chk("R1 no flag when inhibited", si, 0);
    m_bit_in(b); chk("R1 address NACK", b, 1);
    m_stop();
    inhibit = 0;

    // mismatch and write direction
    m_start();
    addr_phase(OWN ^ 7'h01, 1);
    chk("R10 no flag on mismatch", si, 0);
    m_bit_in(b); chk("R10 mismatch NACK", b, 1);
    m_stop();
    m_start();
    addr_phase(OWN, 0);
    chk("R10 no flag on write", si, 0);
    m_bit_in(b); chk("R10 write NACK", b, 1);
    m_stop();

    // firmware NACK, suppression, repeated START
    open_read();
    fw_clear(0);
    irq_ok = 0;
    m_bit_in(b); chk("R3 address NACK", b, 1);
    for (int i = 0; i < 9; i++) m_bit_out(i[0]);
    chk("R3 suppressed", si, 0);
    irq_ok = 1;
    m_start();
    addr_phase(OWN, 1);
    chk("R3 rearmed by START", si, 1);
    fw_clear(0);
    irq_ok = 0;
    m_bit_in(b);
    m_stop();

    // fallback after ACKed address with no data
    open_read();
    fw_clear(1);
    irq_ok = 0;
    m_bit_in(b); chk("R4 address ACK", b, 0);
    read_byte(v); chk("R8 released bus", v, 8'hFF);
    chk("R8 rx_fb", rx_fb, 1);
    chk("R8 tx_mode", tx_mode, 0);
    m_bit_out(0); tick(2);
    chk("R8 no flag", si, 0);
    m_stop();

    // fallback after ACKed byte with no data
    open_read();
    fw_write(8'h0F); exp_q.push_back(8'h0F);
    fw_clear(1);
    m_bit_in(b);
    read_byte(v); chk("R6 byte", v, exp_q.pop_front());
    m_bit_out(0);
    chk("R5 flag", si, 1);
    fw_clear(1);
    irq_ok = 0;
    read_byte(v); chk("R8 released after byte", v, 8'hFF);
    chk("R8 rx_fb after byte", rx_fb, 1);
    m_bit_out(1);
    m_stop(); tick(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule